// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block drives a clock synthesizer through its control register. A single start pulse loads a requested output rate and the three divider fields plus a band code. The sequencer packs them into one control word, writes it with the powerdown and bypass bits cleared, and waits a fixed settling interval sized from the clock frequency. It then samples the synthesizer's lock and error flags exactly once and reports ok, timeout or error on a single-cycle done pulse.

When built for a processor-core clock, the sequencer also handles the divider that feeds the core's interface clock. A rate above the threshold (500 MHz by default) is preceded by a divide-by-2 write, so the interface never runs too fast even briefly. A rate at or below the threshold is followed by a divide-by-1 write, but only after the new setting has been confirmed ok. A plain build leaves that divider alone. The block also reports the output rate implied by the last control word it wrote.

Top module: `pll_reprog_ctrl`

## Requirements
- R1: The control word holds powerdown in bit 0 and bypass in bit 1, both written as 0. The output divider code sits in bits 3:2, the input divider code in bits 8:4, the feedback divider code in bits 15:9, and the band code from bit 20 upward. All other bits are 0.
- R2: Each accepted start produces exactly one control-word write, with a strobe one cycle wide. No two write strobes (control word or interface divider) are ever high in the same cycle.
- R3: Status is sampled in one cycle only: WAIT_CYC = CLK_MHZ × LOCK_US cycles after the control write. Done rises WAIT_CYC+2 cycles after the write strobe, or WAIT_CYC+3 when a trailing divider write occurs. Status values before that sample have no effect.
- R4: Result encoding is 0 = ok, 1 = timeout, 2 = error. A clear lock flag (status bit 0) gives timeout whatever the error flag says. If lock is set and the error flag (status bit 1) is set, the result is error. Otherwise it is ok.
- R5: In core mode with a target rate above THRESH_KHZ, the interface divider receives code 1 (divide-by-2) in the cycle just before the control write. No further divider write follows.
- R6: In core mode with a target rate at or below THRESH_KHZ, the interface divider receives code 0 (divide-by-1) in the cycle just before done, and only if the result is ok. With timeout or error there is no divider write.
- R7: In plain mode (CORE_MODE = 0) the interface divider strobe never rises.
- R8: Done is a one-cycle pulse. The result stays stable after done until the next operation's status sample.
- R9: A start pulse that arrives while an operation is in progress is ignored.
- R10: applied_khz equals PARENT_KHZ × 2 × (fb+1) / ((id+1) × 2^od), taken from the last control word written. It reads the parent rate when the bypass bit is set and 0 when the powerdown bit is set.
- R11: After reset there are no strobes, done is 0, result is 0, and applied_khz is 0, because the held control word resets with powerdown set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| target_khz | input | RATE_W | Requested output rate in kHz, compared with the threshold |
| odiv_code | input | 2 | Output divider code (divide by 2^code) |
| idiv_code | input | 5 | Input divider code (divide by code+1) |
| fbdiv_code | input | 7 | Feedback divider code (multiply by 2×(code+1)) |
| band_code | input | BAND_W | Band selection code |
| pll_lock | input | 1 | Synthesizer lock flag (status bit 0) |
| pll_err | input | 1 | Synthesizer error flag (status bit 1) |
| pll_wr | output | 1 | Control word write strobe |
| pll_wdata | output | 32 | Control word data |
| ifdiv_wr | output | 1 | Interface divider write strobe |
| ifdiv_wdata | output | 1 | Interface divider code (1 = divide-by-2, 0 = divide-by-1) |
| done | output | 1 | Operation complete pulse |
| result | output | 2 | Outcome code, valid from done |
| applied_khz | output | 32 | Rate implied by the last control word written |

## Verification
The bench uses CLK_MHZ = 1 and LOCK_US = 16, so the settling interval is 16 cycles rather than 20,000. At that length the exact sampling cycle can be checked many times over. The bench holds the status flags at the opposite of their intended values for the whole wait and flips them only in the sampling cycle, which exposes any early or repeated sampling. It builds a core-mode instance and a plain instance side by side. Targets of exactly 500,000 and 500,001 kHz probe both sides of the threshold. Divider codes at their field maxima probe the word packing and the rate estimate.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

  localparam int PD_BIT   = 0;
  localparam int BYP_BIT  = 1;
  localparam int ODIV_LSB = 2;
  localparam int IDIV_LSB = 4;
  localparam int FB_LSB   = 9;
  localparam int BAND_LSB = 20;
  localparam int BAND_MAXW = 32 - BAND_LSB;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_ERROR   = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_WRITE, S_WAIT, S_CHECK, S_POST, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic [1:0] odiv;
    logic [4:0] idiv;
    logic [6:0] fbdiv;
  } div_cfg_t;

  // Control word with powerdown and bypass left at zero.
  function automatic logic [31:0] pack_ctrl(input div_cfg_t c,
                                            input logic [BAND_MAXW-1:0] band);
    logic [31:0] w;
    w = '0;
    w[ODIV_LSB +: 2] = c.odiv;
    w[IDIV_LSB +: 5] = c.idiv;
    w[FB_LSB   +: 7] = c.fbdiv;
    w[BAND_LSB +: BAND_MAXW] = band;
    return w;
  endfunction

  // Output rate implied by a control word, in kHz.
  function automatic logic [31:0] est_khz(input logic [31:0] w,
                                          input logic [31:0] parent_khz);
    logic [63:0] num;
    logic [63:0] den;
    logic [63:0] q;
    if (w[BYP_BIT]) begin
      q = {32'd0, parent_khz};
    end else if (w[PD_BIT]) begin
      q = '0;
    end else begin
      num = {32'd0, parent_khz} * (64'd2 * ({57'd0, w[FB_LSB +: 7]} + 64'd1));
      den = ({59'd0, w[IDIV_LSB +: 5]} + 64'd1) << w[ODIV_LSB +: 2];
      q   = num / den;
    end
    return q[31:0];
  endfunction

endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int WAIT_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire = run_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: the count never passes the configured interval
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= LAST));

  // R3: expiry ends the count
  p_expire_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !arm) |=> !run_q);

endmodule

// File: rtl/pll_rate_est.sv
module pll_rate_est
  import pll_reprog_pkg::*;
#(
  parameter int PARENT_KHZ = 33333
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] applied_khz
);
  logic [31:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= 32'h1 << PD_BIT;
    end else if (wr) begin
      word_q <= wdata;
    end
  end

  assign applied_khz = est_khz(word_q, 32'(PARENT_KHZ));

  // R10: the estimate moves only after a control write
  p_est_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr) |-> $stable(applied_khz));

endmodule

// File: rtl/pll_reprog_fsm.sv
module pll_reprog_fsm
  import pll_reprog_pkg::*;
#(
  parameter int CORE_MODE  = 1,
  parameter int RATE_W     = 32,
  parameter int THRESH_KHZ = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] target_khz,
  input  logic              lock,
  input  logic              err,
  input  logic              tmr_expire,
  output logic              accept,
  output logic              pre_wr,
  output logic              ctrl_wr,
  output logic              post_wr,
  output logic              tmr_arm,
  output logic              done,
  output logic [1:0]        result
);
  localparam bit CORE = (CORE_MODE != 0);
  localparam logic [RATE_W-1:0] THRESH = RATE_W'(THRESH_KHZ);

  seq_state_e state_q, state_d;
  logic       above_q;
  res_e       res_q, res_now;
  logic       above_in;

  assign above_in = target_khz > THRESH;
  assign accept   = (state_q == S_IDLE) && start;

  // Lock takes precedence over the error flag.
  always_comb begin
    if (!lock)     res_now = RES_TIMEOUT;
    else if (err)  res_now = RES_ERROR;
    else           res_now = RES_OK;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = (CORE && above_in) ? S_PRE : S_WRITE;
      S_PRE:   state_d = S_WRITE;
      S_WRITE: state_d = S_WAIT;
      S_WAIT:  if (tmr_expire) state_d = S_CHECK;
      S_CHECK: state_d = (CORE && !above_q && res_now == RES_OK) ? S_POST : S_DONE;
      S_POST:  state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      above_q <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      if (accept) above_q <= above_in;
      if (state_q == S_CHECK) res_q <= res_now;
    end
  end

  assign pre_wr  = (state_q == S_PRE);
  assign ctrl_wr = (state_q == S_WRITE);
  assign post_wr = (state_q == S_POST);
  assign tmr_arm = ctrl_wr;
  assign done    = (state_q == S_DONE);
  assign result  = res_q;

  // R6: trailing divider write only after an ok sample
  p_post_after_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    post_wr |-> (res_q == RES_OK) && $past(state_q == S_CHECK));

  // R5: a rate above threshold is preceded by the divide-by-2 write
  p_pre_before_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && CORE && above_q) |-> $past(pre_wr));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: status is sampled only once the interval has run out
  p_check_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CHECK) |-> $past(tmr_expire));

  // R4: missing lock reports timeout
  p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_CHECK) && !lock) |=> (result == RES_TIMEOUT));

  // R4: lock with error flag reports error
  p_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_CHECK) && lock && err) |=> (result == RES_ERROR));

  // R9: a start while busy does not restart the sequence
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_WAIT) && start && !tmr_expire) |=> (state_q == S_WAIT));

endmodule

// File: rtl/pll_reprog_ctrl.sv
module pll_reprog_ctrl
  import pll_reprog_pkg::*;
#(
  parameter int CORE_MODE  = 1,
  parameter int CLK_MHZ    = 200,
  parameter int LOCK_US    = 100,
  parameter int RATE_W     = 32,
  parameter int BAND_W     = 4,
  parameter int THRESH_KHZ = 500000,
  parameter int PARENT_KHZ = 33333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] target_khz,
  input  logic [1:0]        odiv_code,
  input  logic [4:0]        idiv_code,
  input  logic [6:0]        fbdiv_code,
  input  logic [BAND_W-1:0] band_code,
  input  logic              pll_lock,
  input  logic              pll_err,
  output logic              pll_wr,
  output logic [31:0]       pll_wdata,
  output logic              ifdiv_wr,
  output logic              ifdiv_wdata,
  output logic              done,
  output logic [1:0]        result,
  output logic [31:0]       applied_khz
);
  localparam int WAIT_CYC = CLK_MHZ * LOCK_US;

  logic        accept, pre_wr, post_wr, tmr_arm, tmr_expire;
  div_cfg_t    cfg_q;
  logic [BAND_W-1:0] band_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      band_q <= '0;
    end else if (accept) begin
      cfg_q  <= '{odiv: odiv_code, idiv: idiv_code, fbdiv: fbdiv_code};
      band_q <= band_code;
    end
  end

  assign pll_wdata = pack_ctrl(cfg_q, BAND_MAXW'(band_q));

  pll_reprog_fsm #(
    .CORE_MODE (CORE_MODE),
    .RATE_W    (RATE_W),
    .THRESH_KHZ(THRESH_KHZ)
  ) fsm_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .target_khz(target_khz),
    .lock      (pll_lock),
    .err       (pll_err),
    .tmr_expire(tmr_expire),
    .accept    (accept),
    .pre_wr    (pre_wr),
    .ctrl_wr   (pll_wr),
    .post_wr   (post_wr),
    .tmr_arm   (tmr_arm),
    .done      (done),
    .result    (result)
  );

  pll_lock_timer #(.WAIT_CYC(WAIT_CYC)) tmr_u (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (tmr_arm),
    .expire(tmr_expire)
  );

  pll_rate_est #(.PARENT_KHZ(PARENT_KHZ)) est_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (pll_wr),
    .wdata      (pll_wdata),
    .applied_khz(applied_khz)
  );

  generate
    if (CORE_MODE != 0) begin : g_ifdiv
      assign ifdiv_wr    = pre_wr | post_wr;
      assign ifdiv_wdata = pre_wr;
    end else begin : g_no_ifdiv
      logic unused_post;
      assign unused_post = pre_wr | post_wr;
      assign ifdiv_wr    = 1'b0;
      assign ifdiv_wdata = 1'b0;
    end
  endgenerate

  // R2: at most one write strobe per cycle
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pll_wr, ifdiv_wr}) <= 1);

  // R2: the control strobe is one cycle wide
  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pll_wr |=> !pll_wr);

  // R7: plain build never touches the interface divider
  p_plain_no_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (CORE_MODE == 0) |-> !ifdiv_wr);

endmodule

// File: tb/pll_reprog_ctrl_tb_top.sv
module pll_reprog_ctrl_tb_top;
  localparam int CLK_MHZ = 1;
  localparam int LOCK_US = 16;
  localparam int WAITC   = CLK_MHZ * LOCK_US;
  localparam int TH      = 500000;
  localparam int PARENT  = 33333;

  typedef struct packed {
    logic        core;
    logic [31:0] tgt;
    logic [1:0]  od;
    logic [4:0]  id;
    logic [6:0]  fb;
    logic [3:0]  band;
    logic        lk;
    logic        er;
    logic [1:0]  res;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'd600000,  2'd1, 5'd0,  7'd17,  4'd0,  1'b1, 1'b0, 2'd0},
    '{1'b1, 32'd500000,  2'd1, 5'd0,  7'd14,  4'd0,  1'b1, 1'b0, 2'd0},
    '{1'b1, 32'd500001,  2'd1, 5'd0,  7'd14,  4'd3,  1'b0, 1'b0, 2'd1},
    '{1'b1, 32'd300000,  2'd2, 5'd1,  7'd35,  4'd0,  1'b0, 1'b1, 2'd1},
    '{1'b1, 32'd200000,  2'd3, 5'd1,  7'd47,  4'd0,  1'b1, 1'b1, 2'd2},
    '{1'b0, 32'd800000,  2'd1, 5'd0,  7'd23,  4'd0,  1'b1, 1'b0, 2'd0},
    '{1'b0, 32'd100000,  2'd3, 5'd0,  7'd11,  4'd0,  1'b1, 1'b1, 2'd2},
    '{1'b0, 32'd1600000, 2'd0, 5'd1,  7'd47,  4'd15, 1'b0, 1'b1, 2'd1},
    '{1'b1, 32'd1000000, 2'd0, 5'd1,  7'd29,  4'd1,  1'b1, 1'b1, 2'd2},
    '{1'b1, 32'd400000,  2'd3, 5'd31, 7'd127, 4'd15, 1'b1, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, start_c = 1'b0;
  logic [31:0] tgt = '0;
  logic [1:0] od = '0;
  logic [4:0] id = '0;
  logic [6:0] fb = '0;
  logic [3:0] band = '0;
  logic lock = 1'b0, err = 1'b0;

  logic        i_wr, i_dwr, i_dd, i_done, c_wr, c_dwr, c_dd, c_done;
  logic [31:0] i_wd, c_wd, i_app, c_app;
  logic [1:0]  i_res, c_res;

  int checks = 0;
  int errors = 0;
  int c_div_writes = 0;

  always #2.5 clk = ~clk;

  pll_reprog_ctrl #(.CORE_MODE(1), .CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US),
                    .THRESH_KHZ(TH), .PARENT_KHZ(PARENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_i), .target_khz(tgt),
    .odiv_code(od), .idiv_code(id), .fbdiv_code(fb), .band_code(band),
    .pll_lock(lock), .pll_err(err), .pll_wr(i_wr), .pll_wdata(i_wd),
    .ifdiv_wr(i_dwr), .ifdiv_wdata(i_dd), .done(i_done), .result(i_res),
    .applied_khz(i_app));

  pll_reprog_ctrl #(.CORE_MODE(0), .CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US),
                    .THRESH_KHZ(TH), .PARENT_KHZ(PARENT)) dut_c (
    .clk(clk), .rst_n(rst_n), .start(start_c), .target_khz(tgt),
    .odiv_code(od), .idiv_code(id), .fbdiv_code(fb), .band_code(band),
    .pll_lock(lock), .pll_err(err), .pll_wr(c_wr), .pll_wdata(c_wd),
    .ifdiv_wr(c_dwr), .ifdiv_wdata(c_dd), .done(c_done), .result(c_res),
    .applied_khz(c_app));

  always @(negedge clk) if (rst_n && c_dwr) c_div_writes++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_word(input vec_t v);
    return longint'(v.band) * 1048576 + longint'(v.fb) * 512 +
           longint'(v.id) * 16 + longint'(v.od) * 4;
  endfunction

  function automatic longint exp_rate(input vec_t v);
    longint r;
    r = longint'(PARENT) * 2 * (longint'(v.fb) + 1);
    r = r / (longint'(v.id) + 1);
    r = r / (longint'(1) << v.od);
    return r;
  endfunction

  task automatic run_op(input vec_t v, input int n);
    int cyc = 0, pll_cyc = -1, done_cyc = -1, pll_n = 0;
    int pre_n = 0, post_n = 0, pre_cyc = -1, post_cyc = -1, pre_d = 0, post_d = 0;
    longint wd = 0;
    logic s_wr, s_dwr, s_dd, s_done;
    bit exp_pre, exp_post;
    @(negedge clk);
    tgt = v.tgt; od = v.od; id = v.id; fb = v.fb; band = v.band;
    lock = ~v.lk; err = ~v.er;
    if (v.core) start_i = 1'b1; else start_c = 1'b1;
    @(negedge clk);
    start_i = 1'b0; start_c = 1'b0;
    cyc = 1;
    while (done_cyc < 0 && cyc < 200) begin
      s_wr   = v.core ? i_wr   : c_wr;
      s_dwr  = v.core ? i_dwr  : c_dwr;
      s_dd   = v.core ? i_dd   : c_dd;
      s_done = v.core ? i_done : c_done;
      if (s_wr) begin
        pll_n++; pll_cyc = cyc; wd = longint'(v.core ? i_wd : c_wd);
      end
      if (s_dwr) begin
        if (pll_cyc < 0) begin pre_n++; pre_cyc = cyc; pre_d = int'(s_dd); end
        else begin post_n++; post_cyc = cyc; post_d = int'(s_dd); end
      end
      if (s_done) done_cyc = cyc;
      if (pll_cyc >= 0 && cyc == pll_cyc + WAITC + 1) begin
        lock = v.lk; err = v.er;     // only the sampling cycle sees these
      end else if (pll_cyc >= 0 && cyc == pll_cyc + WAITC + 2) begin
        lock = ~v.lk; err = ~v.er;
      end
      @(negedge clk);
      cyc++;
    end
    exp_pre  = v.core && (v.tgt > TH);
    exp_post = v.core && (v.tgt <= TH) && (v.res == 2'd0);
    chk(pll_n == 1, "R2", $sformatf("vec %0d control writes", n), pll_n, 1);
    chk(wd == exp_word(v), "R1", $sformatf("vec %0d control word", n), wd, exp_word(v));
    chk((v.core ? i_res : c_res) == v.res, "R4", $sformatf("vec %0d result", n),
        longint'(v.core ? i_res : c_res), v.res);
    chk(done_cyc - pll_cyc == WAITC + 2 + (exp_post ? 1 : 0), "R3",
        $sformatf("vec %0d write-to-done cycles", n), done_cyc - pll_cyc,
        WAITC + 2 + (exp_post ? 1 : 0));
    if (v.core) begin
      chk(pre_n == (exp_pre ? 1 : 0), "R5", $sformatf("vec %0d leading divider writes", n),
          pre_n, exp_pre ? 1 : 0);
      if (exp_pre) chk(pre_d == 1 && pre_cyc == pll_cyc - 1, "R5",
                       $sformatf("vec %0d leading divider code/cycle", n), pre_d * 1000 + pre_cyc,
                       1000 + pll_cyc - 1);
      chk(post_n == (exp_post ? 1 : 0), "R6", $sformatf("vec %0d trailing divider writes", n),
          post_n, exp_post ? 1 : 0);
      if (exp_post) chk(post_d == 0 && post_cyc == done_cyc - 1, "R6",
                        $sformatf("vec %0d trailing divider code/cycle", n), post_d * 1000 + post_cyc,
                        done_cyc - 1);
    end else begin
      chk(pre_n + post_n == 0, "R7", $sformatf("vec %0d divider writes", n), pre_n + post_n, 0);
    end
    chk(longint'(v.core ? i_app : c_app) == exp_rate(v), "R10",
        $sformatf("vec %0d applied rate", n), longint'(v.core ? i_app : c_app), exp_rate(v));
    repeat (4) @(negedge clk);
    chk((v.core ? i_done : c_done) == 1'b0, "R8", $sformatf("vec %0d done cleared", n),
        longint'(v.core ? i_done : c_done), 0);
    chk((v.core ? i_res : c_res) == v.res, "R8", $sformatf("vec %0d result held", n),
        longint'(v.core ? i_res : c_res), v.res);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int wr_n, done_n;
    repeat (3) @(negedge clk);
    // R11: state during and after reset
    chk(!i_wr && !i_dwr && !i_done && !c_wr && !c_done, "R11", "strobes in reset",
        longint'({i_wr, i_dwr, i_done, c_wr, c_done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(i_res == 2'd0 && c_res == 2'd0, "R11", "result after reset",
        longint'({i_res, c_res}), 0);
    chk(i_app == 32'd0 && c_app == 32'd0, "R11", "applied rate after reset (powerdown)",
        longint'(i_app) + longint'(c_app), 0);

    for (int k = 0; k < NV; k++) run_op(VECS[k], k);

    // R9: repeated start during an operation on the plain instance
    wr_n = 0; done_n = 0;
    @(negedge clk);
    tgt = 32'd700000; od = 2'd1; id = 5'd0; fb = 7'd20; band = 4'd0;
    lock = 1'b1; err = 1'b0;
    start_c = 1'b1;
    @(negedge clk);
    start_c = 1'b0;
    for (int c = 0; c < 3 * WAITC; c++) begin
      if (c == 4 || c == WAITC / 2) start_c = 1'b1;
      else start_c = 1'b0;
      if (c_wr) wr_n++;
      if (c_done) done_n++;
      @(negedge clk);
    end
    start_c = 1'b0;
    chk(wr_n == 1, "R9", "control writes with extra starts", wr_n, 1);
    chk(done_n == 1, "R9", "done pulses with extra starts", done_n, 1);

    // R7: plain instance never wrote the divider over the whole run
    chk(c_div_writes == 0, "R7", "plain-mode divider strobes", c_div_writes, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule